// File: doc/BRIEF.md
# One-Shot Edge-Aligned Pulse Generator

This block is a timebase with a bank of duty comparators that emits one edge-aligned pulse per channel and then stops. Software first presents a period value, one duty value for each channel and a mask of the channels that may drive. It then issues a control write that carries a 2-bit timebase mode and an enable bit. When the mode is one-shot and the timebase is idle, every unmasked channel goes active on the next clock and the counter starts from zero. Each channel goes inactive when the counter reaches that channel's duty value.

When the counter reaches the period value, the run ends. The counter returns to zero, every channel still active is released, the enable status clears itself and the interrupt output pulses for one cycle. To fire again, software issues another enabling write. A control write with the enable bit clear stops a run early and raises no interrupt. All outputs are active-high.

Top module: `spulse_pwm`

## Requirements
- R1: A control write (`cfg_we`=1, `cfg_en`=1) starts a run only when `cfg_mode` equals binary 10. Any other mode code leaves the block idle, with `run_o`=0, `count_o`=0, `pwm_o`=0 and no interrupt.
- R2: On the clock edge that accepts the enabling write, `run_o` becomes 1, `count_o` becomes 0 and every masked-in channel with a nonzero duty goes high, provided the period is nonzero.
- R3: A channel is high exactly while the counter shows a value below both its duty value and the period. It never rises again during a run.
- R4: A duty value of zero keeps that channel low for the whole run.
- R5: A duty value equal to or above the period keeps the channel high until the counter shows the period value, and low in that cycle.
- R6: In the cycle after the counter shows the period value, `count_o` is 0 and all of `pwm_o` is 0. While idle, `count_o` and `pwm_o` stay 0.
- R7: In that same following cycle, `run_o` has cleared and `irq_o` is 1, for exactly one cycle.
- R8: An enabling write made while `run_o`=1 has no effect on the count, the pins or the end of the run. After the run ends, a new enabling write starts a fresh run.
- R9: A control write with `cfg_en`=0 during a run returns the block to idle on the next edge, with the counter and pins at 0 and no interrupt pulse.
- R10: `pin_en_i` bit i, sampled at the accepting edge, gates channel i. A channel whose bit is 0 stays low for the run.
- R11: While running, `count_o` rises by exactly one each clock, from 0 up to the period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_mode | input | 2 | Timebase mode code in the write (10 = one-shot) |
| cfg_en | input | 1 | Enable bit in the write |
| period_i | input | CNT_W | Period value |
| duty_i | input | NCH*CNT_W | Duty values, channel i at bits [i*CNT_W +: CNT_W] |
| pin_en_i | input | NCH | Channel output mask |
| pwm_o | output | NCH | Channel pin levels, active-high |
| irq_o | output | 1 | One-cycle end-of-run pulse |
| run_o | output | 1 | Enable status, clears itself at the end of the run |
| count_o | output | CNT_W | Timebase counter |

## Verification
Each output is registered, so the result of a control write appears one edge after the write is presented. The state the counter shows with value k is visible k edges after the accepting edge. The interrupt and the idle state follow one edge after the counter shows the period. The driver builds the full expected per-cycle trace of a run the moment the start edge passes. The monitor compares one trace entry at every falling edge, half a cycle after the registers update. Disturbing writes (a repeated enable, an abort) are driven at a falling edge, so they land on the edge whose entry the trace already accounts for.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int SPW_CNT_W = 15;
    localparam int SPW_NCH   = 4;

    // Timebase mode code that selects the one-shot run.
    localparam logic [1:0] MODE_ONESHOT = 2'b10;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_START = 2'b01,
        CMD_STOP  = 2'b10
    } spw_cmd_e;

    // Events the timebase hands to every channel for the current cycle.
    typedef struct packed {
        logic start;     // run begins at this edge
        logic stop;      // software abort at this edge
        logic finish;    // counter shows the period: run ends at this edge
        logic last_step; // the next counter value equals the period
        logic has_len;   // period is nonzero
    } spw_evt_t;

    function automatic logic mode_is_oneshot(input logic [1:0] mode);
        return mode == MODE_ONESHOT;
    endfunction

endpackage

// File: rtl/spw_ctl.sv
module spw_ctl
    import spw_pkg::*;
(
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_en,
    input  logic       running,
    output spw_cmd_e   cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (cfg_we) begin
            if (!cfg_en) begin
                if (running) cmd = CMD_STOP;
            end else if (!running && mode_is_oneshot(cfg_mode)) begin
                cmd = CMD_START;
            end
        end
    end

endmodule

// File: rtl/spw_timebase.sv
module spw_timebase
    import spw_pkg::*;
#(
    parameter int CNT_W = SPW_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  spw_cmd_e         cmd,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             run_q,
    output logic             irq_q,
    output spw_evt_t         evt
);

    logic period_hit;

    assign cnt_inc    = cnt_q + CNT_W'(1);
    assign period_hit = run_q && (cnt_q == period);

    always_comb begin
        evt.start     = (cmd == CMD_START);
        evt.stop      = (cmd == CMD_STOP);
        evt.finish    = period_hit && (cmd != CMD_STOP);
        evt.last_step = (cnt_inc == period);
        evt.has_len   = (period != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (evt.start) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (evt.stop) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else if (evt.finish) begin
                run_q <= 1'b0;
                cnt_q <= '0;
                irq_q <= 1'b1;
            end else if (run_q) begin
                cnt_q <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/spw_chan.sv
module spw_chan
    import spw_pkg::*;
#(
    parameter int CNT_W = SPW_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  spw_evt_t         evt,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic [CNT_W-1:0] duty,
    input  logic             pin_en,
    output logic             pin_q
);

    logic duty_nz;
    logic drop_next;

    assign duty_nz   = (duty != '0);
    assign drop_next = (cnt_inc == duty) || evt.last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (evt.start) begin
            pin_q <= pin_en && duty_nz && evt.has_len;
        end else if (evt.stop || evt.finish) begin
            pin_q <= 1'b0;
        end else if (running && drop_next) begin
            pin_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spulse_pwm.sv
module spulse_pwm
    import spw_pkg::*;
#(
    parameter int CNT_W = SPW_CNT_W,
    parameter int NCH   = SPW_NCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_en,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [NCH*CNT_W-1:0] duty_i,
    input  logic [NCH-1:0]       pin_en_i,
    output logic [NCH-1:0]       pwm_o,
    output logic                 irq_o,
    output logic                 run_o,
    output logic [CNT_W-1:0]     count_o
);

    spw_cmd_e         cmd;
    spw_evt_t         evt;
    logic             run_q;
    logic             irq_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [NCH-1:0]   pin_q;

    spw_ctl u_ctl (
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_en   (cfg_en),
        .running  (run_q),
        .cmd      (cmd)
    );

    spw_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .period  (period_i),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc),
        .run_q   (run_q),
        .irq_q   (irq_q),
        .evt     (evt)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        spw_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .running (run_q),
            .cnt_inc (cnt_inc),
            .duty    (duty_i[gi*CNT_W +: CNT_W]),
            .pin_en  (pin_en_i[gi]),
            .pin_q   (pin_q[gi])
        );
    end

    assign pwm_o   = pin_q;
    assign irq_o   = irq_q;
    assign run_o   = run_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/spulse_pwm_chk.sv
module spulse_pwm_chk #(
    parameter int CNT_W = 15,
    parameter int NCH   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             cfg_en,
    input logic [CNT_W-1:0] period,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic [NCH-1:0]   pins
);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_ends_run_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!run && $past(run)));

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (cnt == $past(cnt) + CNT_W'(1)));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !run |-> (cnt == '0 && pins == '0));

    p_period_end_r6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == period) |=> !run);

    p_rearm_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (run && cfg_we && cfg_en && cnt != period) |=> (run && cnt == $past(cnt) + CNT_W'(1)));

    p_no_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> ((pins & ~$past(pins)) == '0));

endmodule

bind spulse_pwm spulse_pwm_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_we (cfg_we),
    .cfg_en (cfg_en),
    .period (period_i),
    .run    (run_o),
    .cnt    (count_o),
    .irq    (irq_o),
    .pins   (pwm_o)
);

// File: tb/spulse_pwm_bench.sv
module spulse_pwm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 15;
    localparam int NC = 4;

    typedef struct {
        bit            run;
        int            cnt;
        logic [NC-1:0] pins;
        bit            irq;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_mode = 2'b00;
    logic              cfg_en = 1'b0;
    logic [CW-1:0]     period_i = '0;
    logic [NC*CW-1:0]  duty_i = '0;
    logic [NC-1:0]     pin_en_i = '0;
    logic [NC-1:0]     pwm_o;
    logic              irq_o;
    logic              run_o;
    logic [CW-1:0]     count_o;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spulse_pwm u_spulse_pwm (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
        .period_i(period_i), .duty_i(duty_i), .pin_en_i(pin_en_i),
        .pwm_o(pwm_o), .irq_o(irq_o), .run_o(run_o), .count_o(count_o)
    );

    function automatic exp_t idle_item(bit irq, string tag);
        exp_t e;
        e.run = 0; e.cnt = 0; e.pins = '0; e.irq = irq; e.tag = tag;
        return e;
    endfunction

    task automatic compare(exp_t e);
        bit bad = 0;
        n_vec++;
        if (run_o !== e.run) begin
            $display("FAIL %s run_o act=%0b exp=%0b", e.tag, run_o, e.run); bad = 1;
        end
        if (count_o !== CW'(e.cnt)) begin
            $display("FAIL %s count_o act=%0d exp=%0d", e.tag, count_o, e.cnt); bad = 1;
        end
        if (pwm_o !== e.pins) begin
            $display("FAIL %s pwm_o act=%b exp=%b", e.tag, pwm_o, e.pins); bad = 1;
        end
        if (irq_o !== e.irq) begin
            $display("FAIL %s irq_o act=%0b exp=%0b", e.tag, irq_o, e.irq); bad = 1;
        end
        if (bad) n_bad++;
    endtask

    // Monitor: one expected item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // Driver for one run. reen_at / abort_at: edge index (0 = start edge) at
    // which a repeated enable or an abort write is applied; -1 for none.
    task automatic fire(int p, int d[NC], logic [NC-1:0] en,
                        int reen_at, int abort_at, string tag);
        int last;
        int endk;
        @(negedge clk);
        period_i = CW'(p);
        for (int i = 0; i < NC; i++) duty_i[i*CW +: CW] = CW'(d[i]);
        pin_en_i = en;
        cfg_mode = 2'b10;
        cfg_en   = 1'b1;
        cfg_we   = 1'b1;
        @(posedge clk);
        last = (abort_at >= 0) ? abort_at - 1 : p;
        for (int k = 0; k <= last; k++) begin
            exp_t e;
            e.run = 1; e.cnt = k; e.irq = 0; e.tag = tag;
            for (int i = 0; i < NC; i++)
                e.pins[i] = en[i] && (k < d[i]) && (k < p);
            sb.push_back(e);
        end
        if (abort_at >= 0) begin
            sb.push_back(idle_item(0, tag));
            sb.push_back(idle_item(0, tag));
        end else begin
            sb.push_back(idle_item(1, tag));
            sb.push_back(idle_item(0, tag));
        end
        @(negedge clk);
        cfg_we = 1'b0;
        endk = (abort_at >= 0) ? abort_at : p + 2;
        for (int k = 1; k <= endk; k++) begin
            if (k == reen_at) begin cfg_we = 1'b1; cfg_en = 1'b1; end
            if (k == abort_at) begin cfg_we = 1'b1; cfg_en = 1'b0; end
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic bad_mode(logic [1:0] m, string tag);
        @(negedge clk);
        cfg_mode = m; cfg_en = 1'b1; cfg_we = 1'b1;
        period_i = CW'(5); duty_i = {NC{CW'(3)}}; pin_en_i = '1;
        @(posedge clk);
        sb.push_back(idle_item(0, tag));
        sb.push_back(idle_item(0, tag));
        @(negedge clk);
        cfg_we = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(idle_item(0, "R6 reset"));
        // R2 R3 R5: mixed duties, one equal to and one above the period
        fire(10, '{3, 7, 10, 12}, 4'b1111, -1, -1, "R2/R3/R5 basic");
        // R4: zero duties stay low
        fire(6, '{0, 1, 5, 0}, 4'b1111, -1, -1, "R4 zero duty");
        // R10: masked channels stay low
        fire(5, '{4, 4, 4, 4}, 4'b0101, -1, -1, "R10 mask");
        // R1: other mode codes do nothing
        bad_mode(2'b00, "R1 mode 00");
        bad_mode(2'b11, "R1 mode 11");
        bad_mode(2'b01, "R1 mode 01");
        // R8: repeated enable mid-run ignored, then re-arm works
        fire(8, '{2, 6, 9, 4}, 4'b1111, 3, -1, "R8 re-enable");
        fire(4, '{1, 2, 3, 4}, 4'b1111, -1, -1, "R8 re-arm");
        // R9: abort then restart
        fire(9, '{5, 8, 2, 9}, 4'b1111, -1, 4, "R9 abort");
        fire(3, '{2, 2, 2, 2}, 4'b1110, -1, -1, "R9 after abort");
        // R7 R11: shortest periods
        fire(0, '{1, 2, 0, 5}, 4'b1111, -1, -1, "R7 zero period");
        fire(1, '{1, 0, 2, 1}, 4'b1111, -1, -1, "R11 period one");
        fire(20, '{19, 20, 21, 10}, 4'b1011, -1, -1, "R11 long");
        summary();
    end

endmodule